// File: doc/BRIEF.md
# Byte-Bus DAC Register Interface

This block sits between an 8-bit processor bus that uses I/O-mapped writes and a 16-bit DAC data path. It takes a write cycle only while both the active-low I/O-request strobe and the active-low write strobe are low. It then decodes the three low address bits as a function offset inside a window of eight addresses. It also compares the upper address bits with a base value set by a parameter. Several instances can therefore sit at different base addresses on one bus.

Two byte writes build a 16-bit word in an input register. A separate update command copies that word into the DAC output register. Two clear commands force both registers to zero. The unipolar zero code is 0x0000 and the bipolar zero code is the offset-binary mid-scale 0x8000.

Each accepted command is carried out once, when the write cycle ends. When it is carried out, a one-cycle pulse marks which function ran.

Top module: `bytebus_dac_regs`

## Requirements
- R1: While reset is asserted and right after it is released, `dac_code` is 0x0000, the input register is 0x0000, and all five pulse outputs are low.
- R2: A cycle in which only one of `iorq_n` and `wr_n` is low has no effect on `dac_code` or on any pulse.
- R3: Offset 0 loads `io_data` into bits 7:0 of the input register, and offset 1 loads it into bits 15:8. The offset is address bits 2:0, so address bit 0 picks the byte. These loads leave `dac_code` unchanged and raise `lo_load_p` or `hi_load_p`.
- R4: Offset 2 and offset 3 both copy the input register into `dac_code` and raise `update_p`.
- R5: Offset 4 sets `dac_code` and the input register to 0x0000 and raises `clr_uni_p`.
- R6: Offset 5 sets `dac_code` and the input register to 0x8000 and raises `clr_bip_p`.
- R7: The value of `io_data` has no effect for offsets 2 through 5.
- R8: A command takes effect once, at the first rising clock edge where the combined strobe is no longer active after having been active. It uses the address and data sampled in the last active cycle, however many cycles the strobe was held.
- R9: Offsets 6 and 7 have no effect.
- R10: A write whose address bits [CMP_W+2:3] differ from `BASE` has no effect.
- R11: Each pulse output is high for exactly one cycle per accepted command, and no two pulses are high together.
- R12: `dac_code` changes only in a cycle in which `update_p`, `clr_uni_p` or `clr_bip_p` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Bus I/O address |
| io_data | input | 8 | Bus write data |
| iorq_n | input | 1 | Active-low I/O request strobe |
| wr_n | input | 1 | Active-low write strobe |
| dac_code | output | 16 | DAC output register |
| lo_load_p | output | 1 | Pulse: low byte loaded |
| hi_load_p | output | 1 | Pulse: high byte loaded |
| update_p | output | 1 | Pulse: output register updated |
| clr_uni_p | output | 1 | Pulse: cleared to unipolar zero |
| clr_bip_p | output | 1 | Pulse: cleared to bipolar zero |

## Verification
The assertions check on every cycle that:
- no two pulses are high together;
- `dac_code` moves only alongside an update or clear pulse;
- each clear leaves its own zero code on the output;
- any pulse follows an active-then-released strobe pattern.

Only the bench scenarios can show the rest, because the assertions cannot see the input register or the intended address map:
- that the two bytes land in the right halves;
- that a clear also rewrites the input register, so a later update yields the clear code;
- that offsets 6 and 7, a wrong base and a single strobe do nothing;
- that command data is ignored.

// File: rtl/bytebus_dac_regs.sv
module bytebus_dac_regs #(
  parameter int ADDR_W = 16,
  parameter int CMP_W  = ADDR_W - 3,
  parameter logic [CMP_W-1:0] BASE = 'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_data,
  input  logic              iorq_n,
  input  logic              wr_n,
  output logic [15:0]       dac_code,
  output logic              lo_load_p,
  output logic              hi_load_p,
  output logic              update_p,
  output logic              clr_uni_p,
  output logic              clr_bip_p
);
  localparam int OFF_W = 3;
  localparam int KEEP_W = OFF_W + CMP_W;
  localparam logic [15:0] UNI_ZERO = 16'h0000;
  localparam logic [15:0] BIP_ZERO = 16'h8000;

  logic              act, act_q, done, hit;
  logic [KEEP_W-1:0] a_q;
  logic [7:0]        d_q;
  logic [15:0]       in_reg;

  assign act  = ~iorq_n & ~wr_n;
  assign done = act_q & ~act;
  assign hit  = a_q[OFF_W +: CMP_W] == BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      a_q       <= '0;
      d_q       <= '0;
      in_reg    <= UNI_ZERO;
      dac_code  <= UNI_ZERO;
      lo_load_p <= 1'b0;
      hi_load_p <= 1'b0;
      update_p  <= 1'b0;
      clr_uni_p <= 1'b0;
      clr_bip_p <= 1'b0;
    end else begin
      act_q     <= act;
      lo_load_p <= 1'b0;
      hi_load_p <= 1'b0;
      update_p  <= 1'b0;
      clr_uni_p <= 1'b0;
      clr_bip_p <= 1'b0;
      if (act) begin
        a_q <= io_addr[KEEP_W-1:0];
        d_q <= io_data;
      end
      if (done && hit) begin
        case (a_q[OFF_W-1:0])
          3'd0: begin in_reg[7:0]  <= d_q; lo_load_p <= 1'b1; end
          3'd1: begin in_reg[15:8] <= d_q; hi_load_p <= 1'b1; end
          3'd2, 3'd3: begin dac_code <= in_reg; update_p <= 1'b1; end
          3'd4: begin in_reg <= UNI_ZERO; dac_code <= UNI_ZERO; clr_uni_p <= 1'b1; end
          3'd5: begin in_reg <= BIP_ZERO; dac_code <= BIP_ZERO; clr_bip_p <= 1'b1; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bytebus_dac_regs_chk.sv
module bytebus_dac_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        iorq_n,
  input logic        wr_n,
  input logic [15:0] dac_code,
  input logic        lo_load_p,
  input logic        hi_load_p,
  input logic        update_p,
  input logic        clr_uni_p,
  input logic        clr_bip_p
);
  logic [4:0] pv;
  assign pv = {lo_load_p, hi_load_p, update_p, clr_uni_p, clr_bip_p};

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pv));

  assert_code_moves_with_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> (update_p || clr_uni_p || clr_bip_p));

  assert_uni_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_uni_p |-> dac_code == 16'h0000);

  assert_bip_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_bip_p |-> dac_code == 16'h8000);

  assert_pulse_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 5'd0) |-> ($past(iorq_n || wr_n) && $past(!iorq_n && !wr_n, 2)));
endmodule

bind bytebus_dac_regs bytebus_dac_regs_chk u_chk (.*);

// File: tb/sim_bytebus_dac_regs.sv
module sim_bytebus_dac_regs;
  localparam int ADDR_W = 16;
  localparam int CMP_W = 13;
  localparam logic [CMP_W-1:0] BASE = 'h24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] io_addr = '0;
  logic [7:0] io_data = '0;
  logic iorq_n = 1'b1, wr_n = 1'b1;
  logic [15:0] dac_code;
  logic lo_load_p, hi_load_p, update_p, clr_uni_p, clr_bip_p;

  int checks = 0, errors = 0;
  logic [15:0] m_in = 16'h0, m_out = 16'h0;

  always #2 clk = ~clk;

  bytebus_dac_regs #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .BASE(BASE)) u0 (.*);

  function automatic logic [ADDR_W-1:0] mk(input logic [2:0] off);
    return {BASE, off};
  endfunction

  function automatic logic [4:0] exp_pulse(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:3] != BASE) return 5'b0;
    case (a[2:0])
      3'd0: return 5'b10000;
      3'd1: return 5'b01000;
      3'd2, 3'd3: return 5'b00100;
      3'd4: return 5'b00010;
      3'd5: return 5'b00001;
      default: return 5'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    if (a[ADDR_W-1:3] == BASE)
      case (a[2:0])
        3'd0: m_in[7:0] = d;
        3'd1: m_in[15:8] = d;
        3'd2, 3'd3: m_out = m_in;
        3'd4: begin m_in = 16'h0; m_out = 16'h0; end
        3'd5: begin m_in = 16'h8000; m_out = 16'h8000; end
        default: ;
      endcase
  endtask

  // mode 0: both strobes, 1: iorq only, 2: wr only
  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input int mode, input int hold, input string req);
    logic [4:0] ep;
    io_addr = a; io_data = d;
    iorq_n = (mode == 2); wr_n = (mode == 1);
    repeat (hold) @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    io_addr = $urandom; io_data = $urandom;
    @(negedge clk);
    ep = (mode == 0) ? exp_pulse(a) : 5'b0;
    if (mode == 0) model(a, d);
    check({req, " pulses"}, {lo_load_p, hi_load_p, update_p, clr_uni_p, clr_bip_p}, ep);
    check({req, " dac_code"}, dac_code, m_out);
  endtask

  task automatic idle_pulse_check(input string req);
    @(negedge clk);
    check(req, {lo_load_p, hi_load_p, update_p, clr_uni_p, clr_bip_p}, 5'b0);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset code", dac_code, 16'h0);
    check("R1 reset pulses", {lo_load_p, hi_load_p, update_p, clr_uni_p, clr_bip_p}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", dac_code, 16'h0);
    bus_wr(mk(3'd2), 8'hFF, 0, 1, "R1 update of reset input reg");

    bus_wr(mk(3'd0), 8'h5A, 0, 1, "R3 low byte");
    idle_pulse_check("R11 single cycle pulse");
    bus_wr(mk(3'd1), 8'hA5, 0, 2, "R3 high byte");
    bus_wr(mk(3'd2), 8'h00, 0, 1, "R4 update at offset 2");
    check("R3 assembled word", dac_code, 16'hA55A);
    bus_wr(mk(3'd0), 8'h11, 0, 1, "R3 low load");
    bus_wr(mk(3'd3), 8'h77, 0, 1, "R4 R7 update at offset 3");
    check("R4 offset 3 value", dac_code, 16'hA511);

    bus_wr(mk(3'd4), 8'hC3, 0, 1, "R5 R7 unipolar clear");
    check("R5 clear code", dac_code, 16'h0000);
    bus_wr(mk(3'd2), 8'h00, 0, 1, "R5 update after clear");
    check("R5 input reg cleared", dac_code, 16'h0000);
    bus_wr(mk(3'd5), 8'h3C, 0, 1, "R6 R7 bipolar clear");
    check("R6 clear code", dac_code, 16'h8000);
    bus_wr(mk(3'd3), 8'h00, 0, 1, "R6 update after clear");
    check("R6 input reg set", dac_code, 16'h8000);

    bus_wr(mk(3'd0), 8'h22, 0, 1, "R3 low load");
    bus_wr(mk(3'd6), 8'h99, 0, 1, "R9 offset 6");
    bus_wr(mk(3'd7), 8'h99, 0, 1, "R9 offset 7");
    bus_wr(mk(3'd2), 8'h00, 0, 1, "R9 update sees no change from 6/7");
    check("R9 word", dac_code, 16'h8022);

    bus_wr({BASE ^ 13'h1, 3'd4}, 8'h00, 0, 1, "R10 wrong base clear");
    bus_wr({BASE ^ 13'h1000, 3'd5}, 8'h00, 0, 1, "R10 wrong base top bit");
    check("R10 unchanged", dac_code, 16'h8022);

    bus_wr(mk(3'd4), 8'h00, 1, 2, "R2 iorq only");
    bus_wr(mk(3'd5), 8'h00, 2, 2, "R2 wr only");
    check("R2 unchanged", dac_code, 16'h8022);

    bus_wr(mk(3'd1), 8'h4E, 0, 7, "R8 long hold");
    idle_pulse_check("R8 acts once");
    bus_wr(mk(3'd2), 8'h00, 0, 1, "R8 update");
    check("R8 word", dac_code, 16'h4E22);

    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      int r, mode;
      r = $urandom_range(0, 99);
      a = (r < 80) ? mk(3'($urandom_range(0, 7))) : ADDR_W'($urandom);
      r = $urandom_range(0, 99);
      mode = (r < 85) ? 0 : ((r < 93) ? 1 : 2);
      bus_wr(a, 8'($urandom), mode, $urandom_range(1, 4), "R12 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule